// File: doc/BRIEF.md
# Dual-Channel Cosine Tone Generator

This block synthesises a digital cosine tone for two 8-bit converter channels. A single 16-bit phase accumulator adds a programmable frequency step on every clock while a global run control is set. It stops and holds its phase while that control is clear. The top eight accumulator bits address a 256-point signed cosine table. Both channels share the table sample, and each channel then applies its own amplitude shift, optional half-cycle inversion and signed DC offset. The sum is centred on mid-code 128 and clamped to the 0..255 code range.

Each channel also holds a static direct code. When the channel's tone enable is clear, the channel drives that code instead of the tone. Writing a direct code turns the channel's tone off. Configuration arrives on plain write strobes with data: one for the frequency step, one for the global run control, one that sets all tone fields of a selected channel, and one that loads a selected channel's direct code. The output frequency is f_clk × step / 65536.

Top module: `tone_gen_dual`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator, step and global run control clear to zero, every channel's tone enable clears, every direct code becomes 128 and every output becomes 128 at that edge.
- R2: A step write whose 20-bit request exceeds 0xFFFF stores 0xFFFF. A smaller request is stored unchanged.
- R3: While the global run control is set, the accumulator adds the stored step at every clock edge, wrapping modulo 65536. While it is clear, the accumulator holds its value and the tone outputs stay constant.
- R4: The table sample is round(127·cos(2π·k/256)), where k is accumulator bits [15:8]. A channel with tone on, scale 0, no inversion and zero offset outputs 128 plus that sample.
- R5: The channel scale field s (0..3) divides the sample by 2^s using an arithmetic right shift of the signed sample.
- R6: A channel whose invert bit is 1 subtracts the scaled sample from mid-code instead of adding it (a 180-degree phase shift).
- R7: The offset is an 8-bit two's-complement value. In both phase settings the output is 128 ± scaled sample + offset. Internally the offset is negated before the inversion stage, so the inversion does not flip its sign.
- R8: A result below 0 outputs 0, and a result above 255 outputs 255.
- R9: A channel with its tone enable clear outputs its direct code. A direct-code write to a channel clears its tone enable, and this write wins over a tone write to the same channel in the same cycle.
- R10: Outputs are registered. A configuration write or an accumulator change taken at one clock edge appears at the outputs at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_wr | input | 1 | Write strobe for the frequency step |
| step_req | input | 20 | Requested frequency step, clamped to 16 bits |
| glob_wr | input | 1 | Write strobe for the global run control |
| glob_val | input | 1 | New value of the global run control |
| chan_wr | input | 1 | Write strobe for the tone fields of one channel |
| chan_sel | input | 1 | Channel addressed by `chan_wr` |
| chan_tone | input | 1 | Tone enable value to write |
| chan_scale | input | 2 | Scale shift to write (0..3) |
| chan_inv | input | 1 | Invert bit to write (1 = 180 degrees) |
| chan_offset | input | 8 | Signed DC offset to write |
| code_wr | input | 1 | Write strobe for a direct code |
| code_sel | input | 1 | Channel addressed by `code_wr` |
| code_val | input | 8 | Direct unsigned code |
| dac_out | output | 16 | Channel 0 code in [7:0], channel 1 code in [15:8] |

## Verification
The assertions assume that each write strobe is a single-cycle pulse sampled at a clock edge. They also assume that `step_req` and the select inputs are stable whenever a strobe is high. The bench drives every input at the falling edge, raises each strobe for exactly one cycle, and only ever addresses the two existing channels. Phase-dependent checks freeze the accumulator by clearing the global run control after a known number of enabled edges. The bench then compares the held output against a cosine computed in real arithmetic, with a tolerance of one code to absorb rounding at the shift.

// File: rtl/tone_pkg.sv
// tone_pkg: shared constants and the cosine table generator used by the
// tone generator. Assumes the table depth is a power of two.
package tone_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Rounded amplitude*cos(2*pi*k/depth) for one table point.
    function automatic int cos_point(int k, int depth, int amp);
        real ang;
        ang = TWO_PI * real'(k) / real'(depth);
        return int'(real'(amp) * $cos(ang));
    endfunction

endpackage

// File: rtl/tone_phase.sv
// tone_phase: holds the clamped frequency step and the global run control,
// and advances the phase accumulator by the step on every clock while running.
// Assumes REQ_W > STEP_W so that clamping is meaningful.
module tone_phase #(
    parameter int STEP_W = 16,
    parameter int REQ_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_wr,
    input  logic [REQ_W-1:0]  step_req,
    input  logic              glob_wr,
    input  logic              glob_val,
    output logic [STEP_W-1:0] step_q,
    output logic              glob_q,
    output logic [STEP_W-1:0] acc_q
);

    localparam logic [REQ_W-1:0] STEP_MAX = {{(REQ_W-STEP_W){1'b0}}, {STEP_W{1'b1}}};

    logic [STEP_W-1:0] step_clamped;

    // Saturate an oversized request to the largest step.
    always_comb begin
        if (step_req > STEP_MAX) begin
            step_clamped = {STEP_W{1'b1}};
        end else begin
            step_clamped = step_req[STEP_W-1:0];
        end
    end

    // Store the step on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (step_wr) begin
            step_q <= step_clamped;
        end
    end

    // Store the global run control on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_q <= 1'b0;
        end else if (glob_wr) begin
            glob_q <= glob_val;
        end
    end

    // Advance the accumulator modulo 2^STEP_W while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (glob_q) begin
            acc_q <= acc_q + step_q;
        end
    end

endmodule

// File: rtl/tone_cos_lut.sv
// tone_cos_lut: combinational signed cosine table with 2^ADDR_W points of
// DATA_W bits, built at elaboration. Peak value is 2^(DATA_W-1)-1.
module tone_cos_lut #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [DATA_W-1:0] sample
);

    import tone_pkg::*;

    localparam int DEPTH = 2 ** ADDR_W;
    localparam int AMP   = (2 ** (DATA_W - 1)) - 1;

    logic signed [DATA_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_point
        assign tbl[i] = DATA_W'(cos_point(i, DEPTH, AMP));
    end

    // Select the addressed point.
    always_comb begin
        sample = tbl[addr];
    end

endmodule

// File: rtl/tone_chan.sv
// tone_chan: one output channel. Holds tone enable, scale, invert, offset
// and direct code, shapes the shared cosine sample and registers the code.
// Assumes the sample magnitude never exceeds 2^(CODE_W-1)-1.
module tone_chan #(
    parameter int CODE_W  = 8,
    parameter int SCALE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic                     cfg_tone,
    input  logic [SCALE_W-1:0]       cfg_scale,
    input  logic                     cfg_inv,
    input  logic [CODE_W-1:0]        cfg_offset,
    input  logic                     code_wr,
    input  logic [CODE_W-1:0]        code_val,
    input  logic signed [CODE_W-1:0] cos_val,
    output logic                     tone_en_q,
    output logic [CODE_W-1:0]        code_q,
    output logic [CODE_W-1:0]        dac_q
);

    localparam int SUM_W = CODE_W + 2;
    localparam logic [CODE_W-1:0] MID = CODE_W'(2 ** (CODE_W - 1));
    localparam logic signed [SUM_W-1:0] MID_S = SUM_W'(2 ** (CODE_W - 1));

    logic [SCALE_W-1:0]       scale_q;
    logic                     inv_q;
    logic [CODE_W-1:0]        off_q;
    logic signed [SUM_W-1:0]  wave_ext;
    logic signed [SUM_W-1:0]  wave_s;
    logic signed [SUM_W-1:0]  off_s;
    logic signed [SUM_W-1:0]  off_eff;
    logic signed [SUM_W-1:0]  pre_s;
    logic signed [SUM_W-1:0]  post_s;
    logic signed [SUM_W-1:0]  centred;
    logic [CODE_W-1:0]        sat_code;
    logic [CODE_W-1:0]        next_code;

    // Tone enable: direct-code write clears it and wins over a tone write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_en_q <= 1'b0;
        end else if (code_wr) begin
            tone_en_q <= 1'b0;
        end else if (cfg_wr) begin
            tone_en_q <= cfg_tone;
        end
    end

    // Scale, invert and offset fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale_q <= '0;
            inv_q   <= 1'b0;
            off_q   <= '0;
        end else if (cfg_wr) begin
            scale_q <= cfg_scale;
            inv_q   <= cfg_inv;
            off_q   <= cfg_offset;
        end
    end

    // Direct code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= MID;
        end else if (code_wr) begin
            code_q <= code_val;
        end
    end

    // Scale the sample, add the pre-negated offset, then apply the inversion.
    always_comb begin
        wave_ext = {{2{cos_val[CODE_W-1]}}, cos_val};
        wave_s   = wave_ext >>> scale_q;
        off_s    = {{2{off_q[CODE_W-1]}}, off_q};
        off_eff  = inv_q ? -off_s : off_s;
        pre_s    = wave_s + off_eff;
        post_s   = inv_q ? -pre_s : pre_s;
        centred  = post_s + MID_S;
    end

    // Clamp the centred result to the unsigned code range.
    always_comb begin
        if (centred[SUM_W-1]) begin
            sat_code = '0;
        end else if (|centred[SUM_W-2:CODE_W]) begin
            sat_code = '1;
        end else begin
            sat_code = centred[CODE_W-1:0];
        end
    end

    // Choose between the tone and the direct code.
    always_comb begin
        next_code = tone_en_q ? sat_code : code_q;
    end

    // Register the channel output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q <= MID;
        end else begin
            dac_q <= next_code;
        end
    end

endmodule

// File: rtl/tone_gen_dual.sv
// tone_gen_dual: multi-channel cosine tone generator. A shared accumulator
// and cosine table feed NCH independently shaped channels.
// Assumes write strobes are single-cycle and selects address existing channels.
module tone_gen_dual #(
    parameter int NCH     = 2,
    parameter int CODE_W  = 8,
    parameter int STEP_W  = 16,
    parameter int REQ_W   = 20,
    parameter int SCALE_W = 2,
    parameter int SEL_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_wr,
    input  logic [REQ_W-1:0]         step_req,
    input  logic                     glob_wr,
    input  logic                     glob_val,
    input  logic                     chan_wr,
    input  logic [SEL_W-1:0]         chan_sel,
    input  logic                     chan_tone,
    input  logic [SCALE_W-1:0]       chan_scale,
    input  logic                     chan_inv,
    input  logic [CODE_W-1:0]        chan_offset,
    input  logic                     code_wr,
    input  logic [SEL_W-1:0]         code_sel,
    input  logic [CODE_W-1:0]        code_val,
    output logic [NCH*CODE_W-1:0]    dac_out
);

    logic [STEP_W-1:0]        step_q;
    logic                     glob_q;
    logic [STEP_W-1:0]        acc_q;
    logic signed [CODE_W-1:0] cos_val;
    logic [NCH-1:0]           tone_en_q;
    logic [NCH*CODE_W-1:0]    code_q;

    tone_phase #(
        .STEP_W (STEP_W),
        .REQ_W  (REQ_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_wr  (step_wr),
        .step_req (step_req),
        .glob_wr  (glob_wr),
        .glob_val (glob_val),
        .step_q   (step_q),
        .glob_q   (glob_q),
        .acc_q    (acc_q)
    );

    tone_cos_lut #(
        .ADDR_W (CODE_W),
        .DATA_W (CODE_W)
    ) u_lut (
        .addr   (acc_q[STEP_W-1 -: CODE_W]),
        .sample (cos_val)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic cfg_hit;
        logic code_hit;

        // Decode the per-channel write strobes.
        always_comb begin
            cfg_hit  = chan_wr && (chan_sel == SEL_W'(c));
            code_hit = code_wr && (code_sel == SEL_W'(c));
        end

        tone_chan #(
            .CODE_W  (CODE_W),
            .SCALE_W (SCALE_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_wr     (cfg_hit),
            .cfg_tone   (chan_tone),
            .cfg_scale  (chan_scale),
            .cfg_inv    (chan_inv),
            .cfg_offset (chan_offset),
            .code_wr    (code_hit),
            .code_val   (code_val),
            .cos_val    (cos_val),
            .tone_en_q  (tone_en_q[c]),
            .code_q     (code_q[c*CODE_W +: CODE_W]),
            .dac_q      (dac_out[c*CODE_W +: CODE_W])
        );
    end

endmodule

// File: rtl/tone_gen_chk.sv
// tone_gen_chk: assertion checker bound to tone_gen_dual. Assumes single-cycle
// write strobes with stable data and selects within range.
module tone_gen_chk #(
    parameter int NCH    = 2,
    parameter int CODE_W = 8,
    parameter int STEP_W = 16,
    parameter int REQ_W  = 20,
    parameter int SEL_W  = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  step_wr,
    input logic [REQ_W-1:0]      step_req,
    input logic                  glob_q,
    input logic [STEP_W-1:0]     step_q,
    input logic [STEP_W-1:0]     acc_q,
    input logic                  code_wr,
    input logic [SEL_W-1:0]      code_sel,
    input logic [NCH-1:0]        tone_en_q,
    input logic [NCH*CODE_W-1:0] code_q,
    input logic [NCH*CODE_W-1:0] dac_out
);

    localparam logic [REQ_W-1:0] REQ_LIMIT = {{(REQ_W-STEP_W){1'b0}}, {STEP_W{1'b1}}};
    localparam logic [CODE_W-1:0] MID = CODE_W'(2 ** (CODE_W - 1));

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_out == {NCH{MID}}) && (acc_q == '0));

    assert_step_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_wr && (step_req > REQ_LIMIT)) |=> (step_q == {STEP_W{1'b1}}));

    assert_acc_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        glob_q |=> (acc_q == STEP_W'($past(acc_q) + $past(step_q))));

    assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_q |=> $stable(acc_q));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_code_clears_tone_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (code_wr && (code_sel == SEL_W'(c))) |=> !tone_en_q[c]);

        assert_direct_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !tone_en_q[c] |=> (dac_out[c*CODE_W +: CODE_W] == $past(code_q[c*CODE_W +: CODE_W])));
    end

endmodule

bind tone_gen_dual tone_gen_chk #(
    .NCH    (NCH),
    .CODE_W (CODE_W),
    .STEP_W (STEP_W),
    .REQ_W  (REQ_W),
    .SEL_W  (SEL_W)
) u_tone_gen_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_wr   (step_wr),
    .step_req  (step_req),
    .glob_q    (glob_q),
    .step_q    (step_q),
    .acc_q     (acc_q),
    .code_wr   (code_wr),
    .code_sel  (code_sel),
    .tone_en_q (tone_en_q),
    .code_q    (code_q),
    .dac_out   (dac_out)
);

// File: tb/test_tone_gen_dual.sv
// test_tone_gen_dual: directed bench, one task per scenario.
module test_tone_gen_dual;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_wr = 1'b0;
    logic [19:0] step_req = '0;
    logic        glob_wr = 1'b0;
    logic        glob_val = 1'b0;
    logic        chan_wr = 1'b0;
    logic [0:0]  chan_sel = '0;
    logic        chan_tone = 1'b0;
    logic [1:0]  chan_scale = '0;
    logic        chan_inv = 1'b0;
    logic [7:0]  chan_offset = '0;
    logic        code_wr = 1'b0;
    logic [0:0]  code_sel = '0;
    logic [7:0]  code_val = '0;
    logic [15:0] dac_out;

    int checks = 0;
    int errors = 0;
    int acc_model = 0;

    tone_gen_dual i_tone_gen_dual (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_wr     (step_wr),
        .step_req    (step_req),
        .glob_wr     (glob_wr),
        .glob_val    (glob_val),
        .chan_wr     (chan_wr),
        .chan_sel    (chan_sel),
        .chan_tone   (chan_tone),
        .chan_scale  (chan_scale),
        .chan_inv    (chan_inv),
        .chan_offset (chan_offset),
        .code_wr     (code_wr),
        .code_sel    (code_sel),
        .code_val    (code_val),
        .dac_out     (dac_out)
    );

    always #5 clk = ~clk;

    function automatic int out_of(int ch);
        return int'(dac_out[ch*8 +: 8]);
    endfunction

    // Expected code from the requirements: 128 +/- (sample >>> s) + offset, clamped.
    function automatic int expect_code(int idx, int s, int inv, int off);
        int c;
        int w;
        int v;
        c = int'(127.0 * $cos(6.283185307179586 * real'(idx) / 256.0));
        w = c >>> s;
        v = 128 + (inv != 0 ? -w : w) + off;
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v;
    endfunction

    task automatic chk(string req, int act, int exp, int tol);
        int d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_chan(int ch, int tone, int s, int inv, int off);
        chan_wr     = 1'b1;
        chan_sel    = 1'(ch);
        chan_tone   = 1'(tone);
        chan_scale  = 2'(s);
        chan_inv    = 1'(inv);
        chan_offset = 8'(off);
        @(negedge clk);
        chan_wr = 1'b0;
    endtask

    task automatic set_code(int ch, int val);
        code_wr  = 1'b1;
        code_sel = 1'(ch);
        code_val = 8'(val);
        @(negedge clk);
        code_wr = 1'b0;
    endtask

    task automatic set_glob(int v);
        glob_wr  = 1'b1;
        glob_val = 1'(v);
        @(negedge clk);
        glob_wr = 1'b0;
    endtask

    task automatic set_step(int req);
        step_wr  = 1'b1;
        step_req = 20'(req);
        @(negedge clk);
        step_wr = 1'b0;
    endtask

    // Run the accumulator for exactly n enabled edges, then wait for the output.
    task automatic run_edges(int n, int step);
        set_glob(1);
        repeat (n - 1) @(negedge clk);
        set_glob(0);
        repeat (2) @(negedge clk);
        acc_model = (acc_model + n * step) % 65536;
    endtask

    task automatic t_reset();
        chk("R1 ch0 reset", out_of(0), 128, 0);
        chk("R1 ch1 reset", out_of(1), 128, 0);
    endtask

    task automatic t_phase_zero();
        chan_wr = 1'b1; chan_sel = 1'b0; chan_tone = 1'b1;
        chan_scale = 2'd0; chan_inv = 1'b0; chan_offset = 8'd0;
        @(negedge clk);
        chan_wr = 1'b0;
        chk("R10 output lags config by one edge", out_of(0), 128, 0);
        @(negedge clk);
        chk("R4 peak sample at index 0", out_of(0), 255, 0);
        set_chan(1, 1, 0, 1, 0);
        @(negedge clk);
        chk("R6 inverted peak", out_of(1), 1, 0);
    endtask

    task automatic t_offset();
        set_chan(0, 1, 0, 0, 10);
        @(negedge clk);
        chk("R8 clamp high", out_of(0), 255, 0);
        set_chan(0, 1, 0, 0, -100);
        @(negedge clk);
        chk("R7 negative offset", out_of(0), 155, 0);
        set_chan(1, 1, 0, 1, 20);
        @(negedge clk);
        chk("R7 offset keeps sign when inverted", out_of(1), 21, 0);
        set_chan(1, 1, 0, 1, -128);
        @(negedge clk);
        chk("R8 clamp low", out_of(1), 0, 0);
    endtask

    task automatic t_scale();
        for (int s = 1; s < 4; s++) begin
            set_chan(0, 1, s, 0, 0);
            @(negedge clk);
            chk("R5 scale shift", out_of(0), expect_code(0, s, 0, 0), 0);
        end
        set_chan(1, 1, 2, 1, 0);
        @(negedge clk);
        chk("R5 scale with inversion", out_of(1), 97, 0);
        set_chan(0, 1, 0, 0, 0);
        set_chan(1, 1, 0, 1, 0);
    endtask

    task automatic t_advance();
        int held;
        set_step(16'h4000);
        run_edges(1, 16'h4000);
        chk("R3 one step to quarter phase", out_of(0), expect_code(acc_model / 256, 0, 0, 0), 1);
        set_step(16'h0800);
        run_edges(5, 16'h0800);
        chk("R3 five steps ch0", out_of(0), expect_code(acc_model / 256, 0, 0, 0), 1);
        chk("R4 five steps ch1 inverted", out_of(1), expect_code(acc_model / 256, 0, 1, 0), 1);
        held = out_of(0);
        repeat (7) @(negedge clk);
        chk("R3 held while stopped", out_of(0), held, 0);
    endtask

    task automatic t_clamp();
        set_step(20'h12345);
        run_edges(64, 16'hFFFF);
        chk("R2 oversized step clamped", out_of(0), expect_code(acc_model / 256, 0, 0, 0), 1);
        set_step(20'h00345);
        run_edges(40, 16'h0345);
        chk("R2 small step unchanged", out_of(0), expect_code(acc_model / 256, 0, 0, 0), 1);
    endtask

    task automatic t_direct();
        int tone1;
        tone1 = out_of(1);
        set_code(0, 8'h37);
        @(negedge clk);
        chk("R9 direct code ch0", out_of(0), 8'h37, 0);
        chk("R9 other channel unaffected", out_of(1), tone1, 0);
        set_chan(0, 1, 0, 0, 0);
        @(negedge clk);
        chk("R9 tone restored", out_of(0), expect_code(acc_model / 256, 0, 0, 0), 1);
        chan_wr = 1'b1; chan_sel = 1'b1; chan_tone = 1'b1;
        chan_scale = 2'd0; chan_inv = 1'b0; chan_offset = 8'd0;
        code_wr = 1'b1; code_sel = 1'b1; code_val = 8'd200;
        @(negedge clk);
        chan_wr = 1'b0;
        code_wr = 1'b0;
        @(negedge clk);
        chk("R9 direct write wins over tone write", out_of(1), 200, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_phase_zero();
        t_offset();
        t_scale();
        t_advance();
        t_clamp();
        t_direct();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule